// File: doc/BRIEF.md
# ATA Device Register File

This block is the register file that sits on the device side of a parallel ATA target. The host selects a register with two active-low chip selects and three address lines, then reads or writes it with active-low read and write strobes. The block holds the command block registers (data, features, sector count, the three LBA bytes, device, command) and the control block register (device control). The alternate status location sits in the control block. Firmware sees the register contents on dedicated outputs, gets a one-cycle pulse when the host writes a command, and drives the busy flag, the remaining status bits, the error byte and an interrupt-raise pulse.

Sector count and the three LBA registers each keep two bytes. The newest write is the current byte, and the byte it replaced is the previous byte, which is how 48-bit addresses and 16-bit counts are loaded. The high-order-byte bit in device control selects which byte the host reads back. Any read while the device is busy returns the status byte. The interrupt request is acknowledged by a status read, is not acknowledged by an alternate status read, and is driven only when enabled and when the device register addresses this device. Strobes are sampled on the block clock. Each assertion of a strobe has its side effect once, at the first clock edge where it is seen low.

Top module: `ata_taskfile`

## Requirements
- R1: With nCs0=0 and nCs1=1, address 0 is data, 1 is error (read) or features (write), 2 is sector count, 3/4/5 are LBA low/mid/high, 6 is device, and 7 is status (read) or command (write). With nCs0=1, nCs1=0 and address 6, a read gives alternate status and a write loads device control. Any other combination reads as zero and its writes change nothing.
- R2: The data register keeps and returns all 16 bits. Every other register uses only bits 7:0, and its reads return zero in bits 15:8.
- R3: A write to sector count or an LBA register moves its current byte to its previous byte and stores the new byte as current. With the high-order-byte bit (device control bit 7) at 0 a read returns the current byte, and at 1 it returns the previous byte. cntOut is {previous, current} count, and lbaOut is {previous high, mid, low, current high, mid, low}.
- R4: Any write to a command block register clears device control bit 7.
- R5: While fwBusy=1, a read of any valid location returns the status byte {fwBusy, fwStatus} in bits 7:0 and zero above.
- R6: Status and alternate status return the same byte. A status read clears the pending interrupt, and an alternate status read leaves it pending.
- R7: intrq is high only when an interrupt is pending, device control bit 1 (interrupt disable) is 0, and device register bit 4 equals devId.
- R8: A fwIrq pulse makes an interrupt pending. A command write or a status read clears it. If a set and a clear meet on the same edge, the set wins.
- R9: A command write raises cmdStrobe for exactly one cycle, in the cycle after the write edge, with cmdCode holding the written byte.
- R10: lbaMode follows device register bit 6 (1 for LBA, 0 for CHS addressing), and devSel follows device register bit 4.
- R11: While device control bit 2 is 1, softRst is high, the command block registers are held at their defaults, command block writes are ignored, and no interrupt is pending. A device control write with bit 2 at 0 releases the hold.
- R12: Defaults after hard reset or soft reset: sector count current 01h, LBA low current 01h, LBA mid and high current 00h, every previous byte 00h, device 00h, features 00h, data 0000h. Hard reset also clears device control to 00h.
- R13: A strobe held low for several cycles has its side effect only once (one history shift, one command pulse). Read data is valid in the same cycle the read strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Hard reset, active low, asynchronous |
| nCs0 | input | 1 | Command block chip select, active low |
| nCs1 | input | 1 | Control block chip select, active low |
| da | input | 3 | Register address |
| nRd | input | 1 | Read strobe, active low |
| nWr | input | 1 | Write strobe, active low |
| hostWrData | input | 16 | Write data from host |
| hostRdData | output | 16 | Read data to host, zero when not reading |
| intrq | output | 1 | Interrupt request to host |
| devId | input | 1 | Identity set by jumper (0 or 1) |
| fwBusy | input | 1 | Busy flag from firmware |
| fwStatus | input | 7 | Status bits 6:0 from firmware |
| fwError | input | 8 | Error register contents from firmware |
| fwIrq | input | 1 | Pulse that raises a pending interrupt |
| cmdStrobe | output | 1 | One-cycle pulse after a command write |
| cmdCode | output | 8 | Last command byte written |
| featOut | output | 8 | Features register |
| cntOut | output | 16 | Sector count {previous, current} |
| lbaOut | output | 48 | LBA {previous high..low, current high..low} |
| lbaMode | output | 1 | Device register addressing mode bit |
| devSel | output | 1 | Device register device-select bit |
| softRst | output | 1 | Soft reset held by device control |

## Verification
Read data is combinational, so the bench lowers the read strobe on a falling clock edge and samples 1 ns later, in that same cycle. Writes, acknowledges and interrupt raises take effect at the first rising edge that sees the strobe or pulse. Register outputs, intrq, softRst and cmdStrobe are therefore checked at the falling edge that follows. cmdStrobe is checked high there and low one cycle later. The soft-reset defaults load at the rising edge after the device control write, and are read back no earlier than the edge after that.

// File: rtl/ata_tf_pkg.sv
package ata_tf_pkg;
  localparam int HIST_N   = 4;  // sector count, lba low, lba mid, lba high
  localparam int HOB_BIT  = 7;
  localparam int SRST_BIT = 2;
  localparam int NIEN_BIT = 1;
  localparam int LBA_BIT  = 6;
  localparam int DRV_BIT  = 4;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_DATA, SEL_ERR, SEL_CNT, SEL_LO, SEL_MID, SEL_HI,
    SEL_DEV, SEL_STAT, SEL_ALT
  } regSel_e;

  typedef struct packed {
    logic              wrData;
    logic              wrFeat;
    logic [HIST_N-1:0] wrHist;
    logic              wrDev;
    logic              wrCmd;
    logic              wrDevCtl;
    logic              ackStat;
  } tfStrobe_t;
endpackage

// File: rtl/ata_tf_ctrl.sv
module ata_tf_ctrl
  import ata_tf_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       nCs0,
  input  logic       nCs1,
  input  logic [2:0] da,
  input  logic       nRd,
  input  logic       nWr,
  input  logic       softRst,
  output regSel_e    rdSel,
  output tfStrobe_t  stb
);
  localparam logic [3:0] CNT_IDX = SEL_CNT;

  logic    rdPrevN, wrPrevN;
  regSel_e sel;
  logic    rdFirst, wrFirst, cmdBlkWr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdPrevN <= 1'b1;
      wrPrevN <= 1'b1;
    end else begin
      rdPrevN <= nRd;
      wrPrevN <= nWr;
    end
  end

  always_comb begin
    sel = SEL_NONE;
    if (!nCs0 && nCs1) begin
      case (da)
        3'd0:    sel = SEL_DATA;
        3'd1:    sel = SEL_ERR;
        3'd2:    sel = SEL_CNT;
        3'd3:    sel = SEL_LO;
        3'd4:    sel = SEL_MID;
        3'd5:    sel = SEL_HI;
        3'd6:    sel = SEL_DEV;
        default: sel = SEL_STAT;
      endcase
    end else if (nCs0 && !nCs1 && da == 3'd6) begin
      sel = SEL_ALT;
    end
  end

  assign rdFirst  = !nRd && rdPrevN;
  assign wrFirst  = !nWr && wrPrevN;
  assign cmdBlkWr = wrFirst && !softRst;
  assign rdSel    = nRd ? SEL_NONE : sel;

  assign stb.wrData   = cmdBlkWr && sel == SEL_DATA;
  assign stb.wrFeat   = cmdBlkWr && sel == SEL_ERR;
  assign stb.wrDev    = cmdBlkWr && sel == SEL_DEV;
  assign stb.wrCmd    = cmdBlkWr && sel == SEL_STAT;
  assign stb.wrDevCtl = wrFirst && sel == SEL_ALT;
  assign stb.ackStat  = rdFirst && sel == SEL_STAT;

  for (genvar g = 0; g < HIST_N; g++) begin : g_histWr
    assign stb.wrHist[g] = cmdBlkWr && (sel == regSel_e'(CNT_IDX + 4'(g)));
  end
endmodule

// File: rtl/ata_tf_datapath.sv
module ata_tf_datapath
  import ata_tf_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int REG_W  = 8
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  tfStrobe_t               stb,
  input  regSel_e                 rdSel,
  input  logic [DATA_W-1:0]       wrData,
  input  logic                    fwBusy,
  input  logic [REG_W-2:0]        fwStatus,
  input  logic [REG_W-1:0]        fwError,
  input  logic                    fwIrq,
  input  logic                    devId,
  output logic [DATA_W-1:0]       rdData,
  output logic                    intrq,
  output logic                    softRst,
  output logic                    cmdStrobe,
  output logic [REG_W-1:0]        cmdCode,
  output logic [REG_W-1:0]        featOut,
  output logic [2*REG_W-1:0]      cntOut,
  output logic [6*REG_W-1:0]      lbaOut,
  output logic                    lbaMode,
  output logic                    devSel
);
  localparam int HW = HIST_N * REG_W;
  localparam int PAD_W = DATA_W - REG_W;

  logic [HW-1:0]     curV, prevV;
  logic [DATA_W-1:0] dataQ;
  logic [REG_W-1:0]  featQ, devQ, devCtlQ;
  logic              pendQ;
  logic [REG_W-1:0]  statusByte, histRd;
  logic              anyCmdWr;
  logic              hob;

  assign softRst    = devCtlQ[SRST_BIT];
  assign hob        = devCtlQ[HOB_BIT];
  assign statusByte = {fwBusy, fwStatus};
  assign anyCmdWr   = stb.wrData | stb.wrFeat | (|stb.wrHist) | stb.wrDev | stb.wrCmd;

  for (genvar g = 0; g < HIST_N; g++) begin : g_hist
    localparam logic [REG_W-1:0] DEF = (g < 2) ? REG_W'(1) : '0;
    logic [REG_W-1:0] curQ, prevQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        curQ  <= DEF;
        prevQ <= '0;
      end else if (softRst) begin
        curQ  <= DEF;
        prevQ <= '0;
      end else if (stb.wrHist[g]) begin
        prevQ <= curQ;
        curQ  <= wrData[REG_W-1:0];
      end
    end
    assign curV[g*REG_W +: REG_W]  = curQ;
    assign prevV[g*REG_W +: REG_W] = prevQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataQ <= '0;
      featQ <= '0;
      devQ  <= '0;
    end else if (softRst) begin
      dataQ <= '0;
      featQ <= '0;
      devQ  <= '0;
    end else begin
      if (stb.wrData) dataQ <= wrData;
      if (stb.wrFeat) featQ <= wrData[REG_W-1:0];
      if (stb.wrDev)  devQ  <= wrData[REG_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      devCtlQ <= '0;
    end else if (stb.wrDevCtl) begin
      devCtlQ <= wrData[REG_W-1:0];
    end else if (anyCmdWr) begin
      devCtlQ[HOB_BIT] <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendQ     <= 1'b0;
      cmdStrobe <= 1'b0;
      cmdCode   <= '0;
    end else begin
      cmdStrobe <= stb.wrCmd;
      if (stb.wrCmd) cmdCode <= wrData[REG_W-1:0];
      if (softRst)                       pendQ <= 1'b0;
      else if (fwIrq)                    pendQ <= 1'b1;
      else if (stb.ackStat || stb.wrCmd) pendQ <= 1'b0;
    end
  end

  always_comb begin
    histRd = '0;
    for (int i = 0; i < HIST_N; i++) begin
      if (rdSel == regSel_e'(4'(SEL_CNT) + 4'(i)))
        histRd = hob ? prevV[i*REG_W +: REG_W] : curV[i*REG_W +: REG_W];
    end
  end

  always_comb begin
    rdData = '0;
    if (rdSel != SEL_NONE && fwBusy) begin
      rdData = {{PAD_W{1'b0}}, statusByte};
    end else begin
      case (rdSel)
        SEL_DATA:                        rdData = dataQ;
        SEL_ERR:                         rdData = {{PAD_W{1'b0}}, fwError};
        SEL_CNT, SEL_LO, SEL_MID, SEL_HI: rdData = {{PAD_W{1'b0}}, histRd};
        SEL_DEV:                         rdData = {{PAD_W{1'b0}}, devQ};
        SEL_STAT, SEL_ALT:               rdData = {{PAD_W{1'b0}}, statusByte};
        default:                         rdData = '0;
      endcase
    end
  end

  assign intrq   = pendQ && !devCtlQ[NIEN_BIT] && (devQ[DRV_BIT] == devId);
  assign featOut = featQ;
  assign cntOut  = {prevV[REG_W-1:0], curV[REG_W-1:0]};
  assign lbaOut  = {prevV[HW-1:REG_W], curV[HW-1:REG_W]};
  assign lbaMode = devQ[LBA_BIT];
  assign devSel  = devQ[DRV_BIT];
endmodule

// File: rtl/ata_taskfile.sv
module ata_taskfile
  import ata_tf_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int REG_W  = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               nCs0,
  input  logic               nCs1,
  input  logic [2:0]         da,
  input  logic               nRd,
  input  logic               nWr,
  input  logic [DATA_W-1:0]  hostWrData,
  output logic [DATA_W-1:0]  hostRdData,
  output logic               intrq,
  input  logic               devId,
  input  logic               fwBusy,
  input  logic [REG_W-2:0]   fwStatus,
  input  logic [REG_W-1:0]   fwError,
  input  logic               fwIrq,
  output logic               cmdStrobe,
  output logic [REG_W-1:0]   cmdCode,
  output logic [REG_W-1:0]   featOut,
  output logic [2*REG_W-1:0] cntOut,
  output logic [6*REG_W-1:0] lbaOut,
  output logic               lbaMode,
  output logic               devSel,
  output logic               softRst
);
  regSel_e   rdSel;
  tfStrobe_t stb;

  ata_tf_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .nCs0(nCs0), .nCs1(nCs1), .da(da),
    .nRd(nRd), .nWr(nWr), .softRst(softRst), .rdSel(rdSel), .stb(stb)
  );

  ata_tf_datapath #(.DATA_W(DATA_W), .REG_W(REG_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .rdSel(rdSel), .wrData(hostWrData),
    .fwBusy(fwBusy), .fwStatus(fwStatus), .fwError(fwError), .fwIrq(fwIrq),
    .devId(devId), .rdData(hostRdData), .intrq(intrq), .softRst(softRst),
    .cmdStrobe(cmdStrobe), .cmdCode(cmdCode), .featOut(featOut),
    .cntOut(cntOut), .lbaOut(lbaOut), .lbaMode(lbaMode), .devSel(devSel)
  );
endmodule

// File: rtl/ata_taskfile_chk.sv
module ata_taskfile_chk #(
  parameter int DATA_W = 16,
  parameter int REG_W  = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              nCs0,
  input logic              nCs1,
  input logic [2:0]        da,
  input logic              nRd,
  input logic              nWr,
  input logic [DATA_W-1:0] hostWrData,
  input logic [DATA_W-1:0] hostRdData,
  input logic              intrq,
  input logic              fwBusy,
  input logic [REG_W-2:0]  fwStatus,
  input logic              fwIrq,
  input logic              cmdStrobe,
  input logic [REG_W-1:0]  cmdCode,
  input logic              softRst
);
  logic cmdSel, altSel;
  assign cmdSel = !nCs0 && nCs1;
  assign altSel = nCs0 && !nCs1 && da == 3'd6;

  // R6: status read acknowledges the interrupt
  a_r6_status_ack: assert property (@(posedge clk) disable iff (!rstN)
    (!nRd && $past(nRd) && nWr && cmdSel && da == 3'd7 && !fwIrq && !softRst) |=> !intrq);

  // R6: alternate status read leaves the interrupt standing
  a_r6_alt_no_ack: assert property (@(posedge clk) disable iff (!rstN)
    (!nRd && $past(nRd) && nWr && altSel && intrq) |=> intrq);

  // R5: busy turns every command block read into status
  a_r5_busy_status: assert property (@(posedge clk) disable iff (!rstN)
    (!nRd && fwBusy && cmdSel) |-> hostRdData == {{(DATA_W-REG_W){1'b0}}, 1'b1, fwStatus});

  // R9: command write gives a pulse carrying the code
  a_r9_cmd_pulse: assert property (@(posedge clk) disable iff (!rstN)
    (!nWr && $past(nWr) && cmdSel && da == 3'd7 && !softRst)
    |=> (cmdStrobe && cmdCode == $past(hostWrData[REG_W-1:0])));

  // R13: the command pulse never lasts two cycles
  a_r13_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    cmdStrobe |=> !cmdStrobe);

  // R11: soft reset drops the interrupt
  a_r11_srst_quiet: assert property (@(posedge clk) disable iff (!rstN)
    softRst |=> !intrq);

  // R1: no read strobe, no read data
  a_r1_idle_zero: assert property (@(posedge clk) disable iff (!rstN)
    nRd |-> hostRdData == '0);
endmodule

bind ata_taskfile ata_taskfile_chk #(.DATA_W(DATA_W), .REG_W(REG_W)) u_chk (
  .clk(clk), .rstN(rstN), .nCs0(nCs0), .nCs1(nCs1), .da(da), .nRd(nRd),
  .nWr(nWr), .hostWrData(hostWrData), .hostRdData(hostRdData), .intrq(intrq),
  .fwBusy(fwBusy), .fwStatus(fwStatus), .fwIrq(fwIrq), .cmdStrobe(cmdStrobe),
  .cmdCode(cmdCode), .softRst(softRst)
);

// File: tb/sim_ata_taskfile.sv
`timescale 1ns/1ps
module sim_ata_taskfile;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic nCs0 = 1'b1, nCs1 = 1'b1, nRd = 1'b1, nWr = 1'b1;
  logic [2:0] da = '0;
  logic [15:0] wdat = '0;
  logic [15:0] rdat;
  logic intrq, devId = 1'b0, fwBusy = 1'b0, fwIrq = 1'b0;
  logic [6:0] fwStatus = 7'h50;
  logic [7:0] fwError = 8'h01;
  logic cmdStrobe, lbaMode, devSel, softRst;
  logic [7:0] cmdCode, featOut;
  logic [15:0] cntOut;
  logic [47:0] lbaOut;

  always #2 clk = ~clk;

  ata_taskfile u0 (
    .clk(clk), .rstN(rstN), .nCs0(nCs0), .nCs1(nCs1), .da(da), .nRd(nRd),
    .nWr(nWr), .hostWrData(wdat), .hostRdData(rdat), .intrq(intrq),
    .devId(devId), .fwBusy(fwBusy), .fwStatus(fwStatus), .fwError(fwError),
    .fwIrq(fwIrq), .cmdStrobe(cmdStrobe), .cmdCode(cmdCode), .featOut(featOut),
    .cntOut(cntOut), .lbaOut(lbaOut), .lbaMode(lbaMode), .devSel(devSel),
    .softRst(softRst)
  );

  int nChecks = 0, nErrs = 0;
  bit done = 0;

  // bench model of the register state
  logic [7:0]  mCur[4], mPrev[4];
  logic [7:0]  mFeat, mDev;
  logic [15:0] mData;
  logic        mHob, mSrst, mNien, mPend;

  task automatic chk(input string tag, input logic [47:0] act, input logic [47:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic void modelDefaults();
    mCur[0] = 8'h01; mCur[1] = 8'h01; mCur[2] = 8'h00; mCur[3] = 8'h00;
    for (int i = 0; i < 4; i++) mPrev[i] = 8'h00;
    mFeat = 8'h00; mDev = 8'h00; mData = 16'h0000; mPend = 1'b0;
  endfunction

  function automatic logic [15:0] expRead(logic c0, logic c1, logic [2:0] a);
    logic [7:0] st = {fwBusy, fwStatus};
    if (!c0 && c1) begin
      if (fwBusy) return {8'h00, st};
      case (a)
        3'd0: return mData;
        3'd1: return {8'h00, fwError};
        3'd6: return {8'h00, mDev};
        3'd7: return {8'h00, st};
        default: return {8'h00, mHob ? mPrev[int'(a) - 2] : mCur[int'(a) - 2]};
      endcase
    end
    if (c0 && !c1 && a == 3'd6) return {8'h00, st};
    return 16'h0000;
  endfunction

  function automatic logic expIntrq();
    return mPend && !mNien && (mDev[4] == devId);
  endfunction

  function automatic void modelWrite(logic c0, logic c1, logic [2:0] a, logic [15:0] d);
    if (!c0 && c1) begin
      if (mSrst) return;
      mHob = 1'b0;
      case (a)
        3'd0: mData = d;
        3'd1: mFeat = d[7:0];
        3'd6: mDev = d[7:0];
        3'd7: mPend = 1'b0;
        default: begin
          mPrev[int'(a) - 2] = mCur[int'(a) - 2];
          mCur[int'(a) - 2] = d[7:0];
        end
      endcase
    end else if (c0 && !c1 && a == 3'd6) begin
      mHob = d[7]; mSrst = d[2]; mNien = d[1];
      if (mSrst) modelDefaults();
    end
  endfunction

  task automatic wrHold(input logic c0, input logic c1, input logic [2:0] a,
                        input logic [15:0] d, input int cyc);
    @(negedge clk); nCs0 = c0; nCs1 = c1; da = a; wdat = d; nWr = 1'b0;
    repeat (cyc) @(negedge clk);
    nWr = 1'b1; nCs0 = 1'b1; nCs1 = 1'b1;
    modelWrite(c0, c1, a, d);
  endtask

  task automatic wr(input logic c0, input logic c1, input logic [2:0] a, input logic [15:0] d);
    wrHold(c0, c1, a, d, 1);
  endtask

  task automatic rd(input logic c0, input logic c1, input logic [2:0] a, input string tag);
    @(negedge clk); nCs0 = c0; nCs1 = c1; da = a; nRd = 1'b0;
    #1 chk(tag, 48'(rdat), 48'(expRead(c0, c1, a)));
    @(negedge clk); nRd = 1'b1; nCs0 = 1'b1; nCs1 = 1'b1;
    if (!c0 && c1 && a == 3'd7) mPend = 1'b0;
  endtask

  task automatic irqPulse();
    @(negedge clk); fwIrq = 1'b1;
    @(negedge clk); fwIrq = 1'b0;
    if (!mSrst) mPend = 1'b1;
  endtask

  task automatic chkOuts(input string tag);
    #1;
    chk({tag, " cntOut"}, 48'(cntOut), 48'({mPrev[0], mCur[0]}));
    chk({tag, " lbaOut"}, lbaOut, {mPrev[3], mPrev[2], mPrev[1], mCur[3], mCur[2], mCur[1]});
    chk({tag, " intrq"}, 48'(intrq), 48'(expIntrq()));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nChecks++; nErrs++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", nErrs, nChecks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    mHob = 0; mSrst = 0; mNien = 0;
    modelDefaults();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R12: defaults after hard reset
    chkOuts("R12 hard reset");
    chk("R12 feat default", 48'(featOut), 48'h0);
    chk("R12 cmdStrobe idle", 48'(cmdStrobe), 48'h0);
    chk("R11 softRst idle", 48'(softRst), 48'h0);
    rd(0, 1, 3'd2, "R12 count reads 01");
    rd(0, 1, 3'd3, "R12 lba low reads 01");
    rd(0, 1, 3'd0, "R12 data reads 0");

    // R13: held write shifts history once
    wrHold(0, 1, 3'd2, 16'h0033, 3);
    chkOuts("R13 held write");

    // R3/R4: history and high-order-byte select
    wr(0, 1, 3'd3, 16'h00A1); wr(0, 1, 3'd3, 16'h00B2);
    wr(0, 1, 3'd5, 16'h00C3);
    wr(1, 0, 3'd6, 16'h0080);
    rd(0, 1, 3'd3, "R3 previous byte with HOB=1");
    rd(0, 1, 3'd2, "R3 previous count with HOB=1");
    wr(0, 1, 3'd1, 16'h0011);
    chk("R4 features written", 48'(featOut), 48'h11);
    rd(0, 1, 3'd3, "R4 HOB cleared by command block write");
    chkOuts("R3 outputs");

    // R2: full-width data register, low byte for the others
    wr(0, 1, 3'd0, 16'hBEEF);
    rd(0, 1, 3'd0, "R2 data 16 bits");
    wr(0, 1, 3'd4, 16'hFF5A);
    rd(0, 1, 3'd4, "R2 upper byte dropped");

    // R1: invalid selections read zero and write nothing
    wr(0, 0, 3'd2, 16'h0055);
    wr(1, 0, 3'd3, 16'h0084);
    rd(0, 0, 3'd2, "R1 both selects low");
    rd(1, 0, 3'd3, "R1 control block bad address");
    rd(1, 1, 3'd2, "R1 no select");
    rd(0, 1, 3'd2, "R1 count unchanged");
    rd(0, 1, 3'd1, "R1 error register");

    // R5: busy returns status everywhere
    fwBusy = 1'b1;
    rd(0, 1, 3'd3, "R5 busy lba low");
    rd(0, 1, 3'd0, "R5 busy data");
    rd(1, 0, 3'd6, "R5 busy alt status");
    fwBusy = 1'b0;

    // R10: device register bits
    wr(0, 1, 3'd6, 16'h0050);
    #1 chk("R10 lbaMode", 48'(lbaMode), 48'h1);
    chk("R10 devSel", 48'(devSel), 48'h1);
    wr(0, 1, 3'd6, 16'h00A0);
    #1 chk("R10 CHS mode", 48'(lbaMode), 48'h0);
    chk("R10 device 0", 48'(devSel), 48'h0);

    // R6/R7/R8: interrupt handling
    wr(1, 0, 3'd6, 16'h0000);
    irqPulse(); chkOuts("R8 raise");
    rd(1, 0, 3'd6, "R6 alt status value");
    chkOuts("R6 alt keeps pending");
    rd(0, 1, 3'd7, "R6 status value");
    chkOuts("R6 status acknowledges");
    irqPulse();
    wr(1, 0, 3'd6, 16'h0002); chkOuts("R7 disabled");
    wr(1, 0, 3'd6, 16'h0000); chkOuts("R7 enabled again");
    wr(0, 1, 3'd6, 16'h0010); chkOuts("R7 other device");
    wr(0, 1, 3'd6, 16'h0000); chkOuts("R7 this device");
    // R8: raise and acknowledge on the same edge
    @(negedge clk); fwIrq = 1'b1; nCs0 = 0; nCs1 = 1; da = 3'd7; nRd = 1'b0;
    @(negedge clk); fwIrq = 1'b0; nRd = 1'b1; nCs0 = 1; nCs1 = 1;
    mPend = 1'b1;
    chkOuts("R8 set wins");

    // R9: command write pulse, clears interrupt
    wr(0, 1, 3'd7, 16'h00EC);
    mPend = 1'b0;
    #1 chk("R9 strobe high", 48'(cmdStrobe), 48'h1);
    chk("R9 code", 48'(cmdCode), 48'hEC);
    chk("R8 cleared by command", 48'(intrq), 48'h0);
    @(negedge clk); #1 chk("R9 strobe one cycle", 48'(cmdStrobe), 48'h0);
    wrHold(0, 1, 3'd7, 16'h0025, 3);
    @(negedge clk); #1 chk("R13 held command single pulse", 48'(cmdStrobe), 48'h0);

    // random mix, R1 R2 R3 R4
    for (int n = 0; n < 400; n++) begin
      int op = int'($urandom_range(0, 9));
      logic [15:0] d = 16'($urandom);
      if (op < 4)       wr(0, 1, 3'(2 + $urandom_range(0, 3)), d);
      else if (op == 4) wr(0, 1, 3'd0, d);
      else if (op == 5) wr(1, 0, 3'd6, {8'h00, d[7], 7'h00});
      else if (op == 6) wr(0, 1, 3'd6, d);
      else if (op == 7) wr(0, 1, 3'd1, d);
      else if (d[15])   rd(1, 0, 3'd6, "R1 random alt read");
      else              rd(0, 1, 3'(d[2:0]), "R3 random read");
    end
    chkOuts("R3 random end");
    chk("R4 random features", 48'(featOut), 48'(mFeat));

    // R11/R12: soft reset
    irqPulse();
    wr(1, 0, 3'd6, 16'h0004);
    #1 chk("R11 softRst high", 48'(softRst), 48'h1);
    wr(0, 1, 3'd2, 16'h0077);
    wr(0, 1, 3'd7, 16'h0090);
    #1 chk("R11 command ignored", 48'(cmdStrobe), 48'h0);
    chkOuts("R11 held");
    wr(1, 0, 3'd6, 16'h0000);
    #1 chk("R11 released", 48'(softRst), 48'h0);
    rd(0, 1, 3'd2, "R12 count after soft reset");
    rd(0, 1, 3'd3, "R12 lba low after soft reset");
    rd(0, 1, 3'd6, "R12 device after soft reset");
    rd(0, 1, 3'd0, "R12 data after soft reset");
    chkOuts("R12 soft reset");
    chk("R12 features after soft reset", 48'(featOut), 48'h0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", nErrs, nChecks);
    $finish;
  end
endmodule